// File: doc/BRIEF.md
# Channel-Routed Priority Interrupt Controller

This block collects up to 64 interrupt request lines and turns them into two prioritized host requests: a fast request and a normal request. Each line is qualified by its own detection mode, either edge or level, in either polarity. A qualified line sets a sticky pending bit. Software clears that bit, by line number or with a bit mask.

A pending line counts only while its enable bit is set. Each line carries a programmable channel number from 0 to 31, and channel number is priority, with 0 the most urgent. The two most urgent channels feed the fast request and all other channels feed the normal request. For each host request a readable register names the winning line. Each host request is gated by its own enable and by one global enable, and is registered before it leaves the block.

Software reaches all state through one synchronous register port. A write takes effect at the clock edge where it is presented. Read data is combinational from the word address.

Top module: `chmap_intc`

## Requirements
- R1: After reset, all line enables, detection-type bits, host enables and the global enable are 0. All polarity bits are 1. Every channel byte reads 0x0F, so each map word reads 0x0F0F0F0F. Both winner registers read 0x8000_0000 and both host outputs are low.
- R2: A line with type bit 1 sets its pending bit in the cycle its sampled value changes in the selected direction: polarity 1 selects 0 to 1, and polarity 0 selects 1 to 0. A steady level and a change in the other direction set nothing.
- R3: A line with type bit 0 sets its pending bit in every cycle its level equals its polarity bit. The bit stays set after the level goes away and is only removed by a clear. A clear applied while the level is still active leaves the bit set.
- R4: Writing a line number N to word 0x01 clears only pending bit N. A value of 64 or more changes nothing.
- R5: Writing a mask to status word 0x10+w clears the pending bit of line 32w+b for every mask bit b that is 1. Mask bits that are 0 leave their pending bits unchanged. Reading the same word returns the pending bits.
- R6: Writing a line number to 0x02 sets that line's enable, and writing it to 0x03 clears it. Line numbers of 64 or more are ignored. A 1 bit in word 0x14+w sets the matching enable and a 1 bit in 0x18+w clears it. Both words read back the enables. A pending line that is not enabled takes no part in priority and drives no output.
- R7: Map word 0x40+g holds the channels of lines 4g to 4g+3, one byte each, with line 4g in bits 7:0 and line 4g+3 in bits 31:24. Only the low 5 bits of each byte are stored, and the upper 3 bits read as 0. Type words are at 0x1C+w and polarity words at 0x20+w, with bit b of word w belonging to line 32w+b.
- R8: The winner register of a host returns, in bits 5:0, the enabled pending line whose channel is the lowest within that host's channel range. A tie is broken by the lowest line number. When no line qualifies, bit 31 is set and the register reads 0x8000_0000.
- R9: Channels 0 and 1 belong to the fast host, whose winner register is at 0x08. Channels 2 to 31 belong to the normal host, whose winner register is at 0x09.
- R10: A host output is high in the cycle after a cycle in which global enable (0x00 bit 0), that host's enable, and a qualifying line all held. The host enables are bit 0 (fast) and bit 1 (normal) of word 0x06. A host index of 0 or 1 written to 0x04 sets one of them and written to 0x05 clears it; other index values are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 64 | Interrupt request lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| host_fast_o | output | 1 | Fast host request, registered |
| host_norm_o | output | 1 | Normal host request, registered |

## Verification
Directed patterns test one effect at a time:
- a single line is driven through rising edges, falling edges and held levels, which separates the edge detector from the level path and shows which clears stick;
- lines are mapped to channel 1, channel 2 and channel 15, which shows the fast/normal split and the channel-over-index ordering;
- the global and host enables are switched off one at a time, which shows each gate on its own.

A seeded random phase then toggles sparse input bits while mixing in index and word clears, enable changes, remapping and mode rewrites. This exposes priority ties and clear/set collisions that the directed cases do not reach.

// File: rtl/icc_pkg.sv
package icc_pkg;
    localparam int ADDR_W = 7;

    // register word addresses
    localparam logic [ADDR_W-1:0] A_GLB      = 7'h00;
    localparam logic [ADDR_W-1:0] A_STAT_ICLR = 7'h01;
    localparam logic [ADDR_W-1:0] A_EN_ISET  = 7'h02;
    localparam logic [ADDR_W-1:0] A_EN_ICLR  = 7'h03;
    localparam logic [ADDR_W-1:0] A_HEN_ISET = 7'h04;
    localparam logic [ADDR_W-1:0] A_HEN_ICLR = 7'h05;
    localparam logic [ADDR_W-1:0] A_HEN      = 7'h06;
    localparam logic [ADDR_W-1:0] A_PRI_F    = 7'h08;
    localparam logic [ADDR_W-1:0] A_PRI_N    = 7'h09;
    localparam logic [ADDR_W-1:0] A_STAT     = 7'h10;
    localparam logic [ADDR_W-1:0] A_EN_SET   = 7'h14;
    localparam logic [ADDR_W-1:0] A_EN_CLR   = 7'h18;
    localparam logic [ADDR_W-1:0] A_TYPE     = 7'h1C;
    localparam logic [ADDR_W-1:0] A_POL      = 7'h20;
    localparam logic [ADDR_W-1:0] A_MAP      = 7'h40;

    localparam int LINES_PER_WORD = 32;
    localparam int LINES_PER_MAP  = 4;
    localparam int HOSTS          = 2;
endpackage

// File: rtl/icc_detect.sv
module icc_detect #(
    parameter int N = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] in_i,
    input  logic [N-1:0] type_i,
    input  logic [N-1:0] pol_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] pend;
    } det_t;

    det_t st_d, st_q;
    logic [N-1:0] rise, fall, edge_hit, lvl_hit, set_v;

    always_comb begin
        rise     = in_i & ~st_q.prev;
        fall     = ~in_i & st_q.prev;
        edge_hit = (pol_i & rise) | (~pol_i & fall);
        lvl_hit  = ~(in_i ^ pol_i);
        set_v    = (type_i & edge_hit) | (~type_i & lvl_hit);
        st_d.prev = in_i;
        // a new detection wins over a clear in the same cycle
        st_d.pend = (st_q.pend & ~clr_i) | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;

    // pending bits only drop through a clear
    assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((($past(st_q.pend) & ~$past(clr_i)) & ~st_q.pend) == '0));
endmodule

// File: rtl/icc_pick.sv
module icc_pick #(
    parameter int               N      = 64,
    parameter int               NUM_CH = 32,
    parameter logic [NUM_CH-1:0] CH_MASK = '1,
    localparam int              CH_W   = $clog2(NUM_CH),
    localparam int              IDX_W  = $clog2(N)
) (
    input  logic [N-1:0]      act_i,
    input  logic [N*CH_W-1:0] map_i,
    output logic              found_o,
    output logic [IDX_W-1:0]  idx_o
);
    logic [CH_W-1:0] ch;
    logic [CH_W-1:0] best;

    // ascending scan with a strict compare keeps the lowest line on ties
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        best    = '0;
        ch      = '0;
        for (int i = 0; i < N; i++) begin
            ch = map_i[i*CH_W +: CH_W];
            if (act_i[i] && CH_MASK[ch] && (!found_o || ch < best)) begin
                found_o = 1'b1;
                best    = ch;
                idx_o   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/chmap_intc.sv
module chmap_intc
    import icc_pkg::*;
#(
    parameter int NUM_IN  = 64,
    parameter int NUM_CH  = 32,
    parameter int FAST_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] irq_in,
    input  logic              reg_we,
    input  logic [6:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              host_fast_o,
    output logic              host_norm_o
);
    localparam int CH_W  = $clog2(NUM_CH);
    localparam int IDX_W = $clog2(NUM_IN);
    localparam logic [CH_W-1:0]   MAP_RST   = CH_W'(15);
    localparam logic [NUM_CH-1:0] FAST_MASK = NUM_CH'((1 << FAST_CH) - 1);

    typedef struct packed {
        logic [NUM_IN-1:0]           en;
        logic [NUM_IN-1:0]           typ;
        logic [NUM_IN-1:0]           pol;
        logic [NUM_IN-1:0][CH_W-1:0] map;
        logic                        glb;
        logic [HOSTS-1:0]            hen;
        logic [HOSTS-1:0]            host;
    } cfg_t;

    cfg_t st_d, st_q;

    logic [NUM_IN-1:0] clr, pend, act;
    logic [HOSTS-1:0]  found;
    logic [IDX_W-1:0]  pick_idx [HOSTS];
    logic              idx_ok, hidx_ok;
    logic [IDX_W-1:0]  widx;

    icc_detect #(.N(NUM_IN)) u_detect (
        .clk   (clk),
        .rst_n (rst_n),
        .in_i  (irq_in),
        .type_i(st_q.typ),
        .pol_i (st_q.pol),
        .clr_i (clr),
        .pend_o(pend)
    );

    assign act = pend & st_q.en;

    for (genvar h = 0; h < HOSTS; h++) begin : g_host
        localparam logic [NUM_CH-1:0] MASK = (h == 0) ? FAST_MASK : ~FAST_MASK;
        icc_pick #(.N(NUM_IN), .NUM_CH(NUM_CH), .CH_MASK(MASK)) u_pick (
            .act_i  (act),
            .map_i  (st_q.map),
            .found_o(found[h]),
            .idx_o  (pick_idx[h])
        );
    end

    assign idx_ok  = reg_wdata < 32'(NUM_IN);
    assign hidx_ok = reg_wdata < 32'(HOSTS);
    assign widx    = reg_wdata[IDX_W-1:0];

    // next-state of all configuration and outputs
    always_comb begin
        st_d = st_q;
        clr  = '0;
        if (reg_we) begin
            if (reg_addr == A_GLB) st_d.glb = reg_wdata[0];
            if (reg_addr == A_HEN) st_d.hen = reg_wdata[HOSTS-1:0];
            if (hidx_ok && reg_addr == A_HEN_ISET) st_d.hen[reg_wdata[0]] = 1'b1;
            if (hidx_ok && reg_addr == A_HEN_ICLR) st_d.hen[reg_wdata[0]] = 1'b0;
            if (idx_ok) begin
                if (reg_addr == A_STAT_ICLR) clr[widx]     = 1'b1;
                if (reg_addr == A_EN_ISET)   st_d.en[widx] = 1'b1;
                if (reg_addr == A_EN_ICLR)   st_d.en[widx] = 1'b0;
            end
            for (int i = 0; i < NUM_IN; i++) begin
                if (reg_addr == A_STAT + 7'(i / LINES_PER_WORD) && reg_wdata[i % LINES_PER_WORD])
                    clr[i] = 1'b1;
                if (reg_addr == A_EN_SET + 7'(i / LINES_PER_WORD) && reg_wdata[i % LINES_PER_WORD])
                    st_d.en[i] = 1'b1;
                if (reg_addr == A_EN_CLR + 7'(i / LINES_PER_WORD) && reg_wdata[i % LINES_PER_WORD])
                    st_d.en[i] = 1'b0;
                if (reg_addr == A_TYPE + 7'(i / LINES_PER_WORD))
                    st_d.typ[i] = reg_wdata[i % LINES_PER_WORD];
                if (reg_addr == A_POL + 7'(i / LINES_PER_WORD))
                    st_d.pol[i] = reg_wdata[i % LINES_PER_WORD];
                if (reg_addr == A_MAP + 7'(i / LINES_PER_MAP))
                    st_d.map[i] = reg_wdata[(i % LINES_PER_MAP)*8 +: CH_W];
            end
        end
        for (int h = 0; h < HOSTS; h++) begin
            st_d.host[h] = st_q.glb & st_q.hen[h] & found[h];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.en   <= '0;
            st_q.typ  <= '0;
            st_q.pol  <= '1;
            st_q.map  <= {NUM_IN{MAP_RST}};
            st_q.glb  <= 1'b0;
            st_q.hen  <= '0;
            st_q.host <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_GLB) reg_rdata[0] = st_q.glb;
        if (reg_addr == A_HEN) reg_rdata[HOSTS-1:0] = st_q.hen;
        if (reg_addr == A_PRI_F) begin
            reg_rdata[31]          = ~found[0];
            reg_rdata[IDX_W-1:0]   = pick_idx[0];
        end
        if (reg_addr == A_PRI_N) begin
            reg_rdata[31]          = ~found[1];
            reg_rdata[IDX_W-1:0]   = pick_idx[1];
        end
        for (int i = 0; i < NUM_IN; i++) begin
            if (reg_addr == A_STAT + 7'(i / LINES_PER_WORD))
                reg_rdata[i % LINES_PER_WORD] = pend[i];
            if (reg_addr == A_EN_SET + 7'(i / LINES_PER_WORD) ||
                reg_addr == A_EN_CLR + 7'(i / LINES_PER_WORD))
                reg_rdata[i % LINES_PER_WORD] = st_q.en[i];
            if (reg_addr == A_TYPE + 7'(i / LINES_PER_WORD))
                reg_rdata[i % LINES_PER_WORD] = st_q.typ[i];
            if (reg_addr == A_POL + 7'(i / LINES_PER_WORD))
                reg_rdata[i % LINES_PER_WORD] = st_q.pol[i];
            if (reg_addr == A_MAP + 7'(i / LINES_PER_MAP))
                reg_rdata[(i % LINES_PER_MAP)*8 +: CH_W] = st_q.map[i];
        end
    end

    assign host_fast_o = st_q.host[0];
    assign host_norm_o = st_q.host[1];

    // winner of each host is an enabled pending line on that host's channels
    assert_fast_pick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        found[0] |-> (act[pick_idx[0]] && (st_q.map[pick_idx[0]] < CH_W'(FAST_CH))));
    assert_norm_pick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        found[1] |-> (act[pick_idx[1]] && (st_q.map[pick_idx[1]] >= CH_W'(FAST_CH))));
    // an output is only high after a cycle with both enables and a winner
    assert_fast_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (!host_fast_o || $past(st_q.glb && st_q.hen[0] && found[0])));
    assert_norm_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (!host_norm_o || $past(st_q.glb && st_q.hen[1] && found[1])));
endmodule

// File: tb/sim_chmap_intc.sv
`timescale 1ns/1ps
module sim_chmap_intc;
    localparam logic [6:0] GLB = 7'h00, SICLR = 7'h01, EISET = 7'h02, EICLR = 7'h03;
    localparam logic [6:0] HISET = 7'h04, HICLR = 7'h05, HEN = 7'h06;
    localparam logic [6:0] PRIF = 7'h08, PRIN = 7'h09, STAT = 7'h10, ESET = 7'h14;
    localparam logic [6:0] ECLR = 7'h18, TYP = 7'h1C, POL = 7'h20, MAP = 7'h40;

    logic        clk = 0, rst_n = 0, reg_we = 0;
    logic [63:0] irq_in = '0;
    logic [6:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        host_fast_o, host_norm_o;

    int total = 0, bad = 0;

    logic [63:0] m_pend, m_en, m_typ, m_pol, cur_in, prev_in;
    logic [4:0]  m_map [64];
    logic        m_glb;
    logic [1:0]  m_hen;

    chmap_intc u0 (.*);

    always #5 clk = ~clk;

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    function automatic int best_line(input int h);
        int b = -1;
        int bch = 99;
        for (int i = 0; i < 64; i++) begin
            if (m_pend[i] && m_en[i] && ((h == 0) == (m_map[i] < 5'd2)) && int'(m_map[i]) < bch) begin
                bch = int'(m_map[i]);
                b = i;
            end
        end
        return b;
    endfunction

    function automatic logic [31:0] exp_pri(input int h);
        int b = best_line(h);
        return (b < 0) ? 32'h8000_0000 : 32'(b);
    endfunction

    function automatic logic exp_host(input int h);
        return m_glb && m_hen[h] && (best_line(h) >= 0);
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.25;
        d = reg_rdata;
    endtask

    task automatic rchk(input string tag, input logic [6:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(tag, d, exp);
    endtask

    // one clock cycle with an optional write; the model follows the requirements
    task automatic cyc(input logic we, input logic [6:0] a, input logic [31:0] d);
        logic ef, en_;
        logic [63:0] setv, clrv;
        @(negedge clk);
        irq_in = cur_in; reg_we = we; reg_addr = a; reg_wdata = d;
        ef  = exp_host(0);
        en_ = exp_host(1);
        @(posedge clk); #1;
        reg_we = 0;
        setv = '0; clrv = '0;
        for (int i = 0; i < 64; i++) begin
            if (m_typ[i]) begin
                if (m_pol[i]) setv[i] = cur_in[i] && !prev_in[i];
                else          setv[i] = !cur_in[i] && prev_in[i];
            end else begin
                setv[i] = (cur_in[i] == m_pol[i]);
            end
        end
        if (we) begin
            if (a == SICLR && d < 64) clrv[d[5:0]] = 1'b1;
            if (a == STAT)     clrv[31:0]  = d;
            if (a == STAT + 1) clrv[63:32] = d;
        end
        m_pend = (m_pend & ~clrv) | setv;
        prev_in = cur_in;
        if (we) begin
            case (a)
                GLB:      m_glb = d[0];
                HEN:      m_hen = d[1:0];
                HISET:    if (d < 2) m_hen[d[0]] = 1'b1;
                HICLR:    if (d < 2) m_hen[d[0]] = 1'b0;
                EISET:    if (d < 64) m_en[d[5:0]] = 1'b1;
                EICLR:    if (d < 64) m_en[d[5:0]] = 1'b0;
                ESET:     m_en[31:0]  = m_en[31:0] | d;
                ESET + 1: m_en[63:32] = m_en[63:32] | d;
                ECLR:     m_en[31:0]  = m_en[31:0] & ~d;
                ECLR + 1: m_en[63:32] = m_en[63:32] & ~d;
                TYP:      m_typ[31:0]  = d;
                TYP + 1:  m_typ[63:32] = d;
                POL:      m_pol[31:0]  = d;
                POL + 1:  m_pol[63:32] = d;
                default: begin
                    if (a >= MAP && a < MAP + 16) begin
                        for (int k = 0; k < 4; k++) m_map[4*(a - MAP) + k] = d[8*k +: 5];
                    end
                end
            endcase
        end
        chk("R10 fast output", {31'd0, host_fast_o}, {31'd0, ef});
        chk("R10 normal output", {31'd0, host_norm_o}, {31'd0, en_});
    endtask

    task automatic chk_all(input string tag);
        rchk({tag, " status0"}, STAT, m_pend[31:0]);
        rchk({tag, " status1"}, STAT + 1, m_pend[63:32]);
        rchk({tag, " R6 enable0"}, ESET, m_en[31:0]);
        rchk({tag, " R6 enable1"}, ESET + 1, m_en[63:32]);
        rchk({tag, " R8 fast winner"}, PRIF, exp_pri(0));
        rchk({tag, " R9 normal winner"}, PRIN, exp_pri(1));
    endtask

    initial begin
        void'($urandom(32'd2024));
        m_pend = '0; m_en = '0; m_typ = '0; m_pol = '1; cur_in = '0; prev_in = '0;
        for (int i = 0; i < 64; i++) m_map[i] = 5'd15;
        m_glb = 0; m_hen = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R1 reset state
        rchk("R1 map word", MAP, 32'h0F0F_0F0F);
        rchk("R1 fast winner", PRIF, 32'h8000_0000);
        rchk("R1 normal winner", PRIN, 32'h8000_0000);
        rchk("R1 enables", ESET + 1, 32'h0);
        rchk("R1 polarity", POL, 32'hFFFF_FFFF);
        chk("R1 outputs", {30'd0, host_fast_o, host_norm_o}, 32'h0);

        // enables
        cyc(1, GLB, 1); cyc(1, HISET, 0); cyc(1, HISET, 1); cyc(1, HISET, 7);
        rchk("R10 host enables", HEN, 32'h3);
        cyc(1, ESET, 32'hFFFF_FFFF); cyc(1, ESET + 1, 32'hFFFF_FFFF);

        // R2 edge detection on line 3
        cyc(1, TYP, 32'h8);
        cur_in[3] = 1; cyc(0, GLB, 0);
        rchk("R2 rising sets", STAT, 32'h8);
        rchk("R8 normal winner line 3", PRIN, 32'd3);
        cyc(1, SICLR, 3); cyc(0, GLB, 0);
        rchk("R2 steady high sets nothing", STAT, 32'h0);
        cur_in[3] = 0; cyc(0, GLB, 0);
        rchk("R2 falling ignored", STAT, 32'h0);
        cyc(1, POL, 32'hFFFF_FFF7);
        cur_in[3] = 1; cyc(0, GLB, 0);
        rchk("R2 rising ignored in falling mode", STAT, 32'h0);
        cur_in[3] = 0; cyc(0, GLB, 0);
        rchk("R2 falling sets", STAT, 32'h8);
        cyc(1, STAT, 32'h8);
        rchk("R5 word clear", STAT, 32'h0);

        // R3 level on line 5
        cur_in[5] = 1; cyc(0, GLB, 0);
        rchk("R3 level sets", STAT, 32'h20);
        cur_in[5] = 0; cyc(0, GLB, 0);
        rchk("R3 sticky after level drops", STAT, 32'h20);
        cyc(1, SICLR, 5);
        rchk("R3 cleared", STAT, 32'h0);
        cur_in[5] = 1; cyc(0, GLB, 0); cyc(1, SICLR, 5);
        rchk("R3 clear while level held", STAT, 32'h20);

        // R4 index clear
        cur_in[5] = 0; cur_in[40] = 1; cyc(0, GLB, 0);
        cur_in[40] = 0; cyc(0, GLB, 0);
        cyc(1, SICLR, 64);
        rchk("R4 out of range ignored lo", STAT, 32'h20);
        rchk("R4 out of range ignored hi", STAT + 1, 32'h100);
        cyc(1, SICLR, 40);
        rchk("R4 only line 40 cleared hi", STAT + 1, 32'h0);
        rchk("R4 only line 40 cleared lo", STAT, 32'h20);

        // R5 zero mask
        cyc(1, STAT, 32'h0);
        rchk("R5 zero bits no effect", STAT, 32'h20);
        cyc(1, STAT, 32'h20);

        // R6 enables
        cur_in[40] = 1; cyc(0, GLB, 0); cur_in[40] = 0; cyc(0, GLB, 0);
        cyc(1, EICLR, 40);
        rchk("R6 disabled line ignored", PRIN, 32'h8000_0000);
        rchk("R6 index clear", ESET + 1, 32'hFFFF_FEFF);
        cyc(0, GLB, 0);
        chk("R6 output follows disable", {31'd0, host_norm_o}, 32'h0);
        cyc(1, EISET, 40);
        rchk("R6 index set", ECLR + 1, 32'hFFFF_FFFF);
        rchk("R6 re-enabled winner", PRIN, 32'd40);
        cyc(1, ECLR + 1, 32'hFFFF_FFFF);
        rchk("R6 word clear", ESET + 1, 32'h0);
        cyc(1, ESET + 1, 32'h100);

        // R7 map layout, R9 split
        cyc(1, MAP + 1, 32'h1F03_0201);
        rchk("R7 map readback", MAP + 1, 32'h1F03_0201);
        cyc(1, MAP + 1, 32'hE1E2_E3E4);
        rchk("R7 upper bits dropped", MAP + 1, 32'h0102_0304);
        cur_in[6] = 1; cur_in[7] = 1; cyc(0, GLB, 0);
        cur_in[6] = 0; cur_in[7] = 0; cyc(0, GLB, 0);
        rchk("R9 channel 1 on fast", PRIF, 32'd7);
        rchk("R8 channel 2 beats 15", PRIN, 32'd6);

        // R10 gating
        cyc(1, GLB, 0); cyc(0, GLB, 0);
        chk("R10 global off", {30'd0, host_fast_o, host_norm_o}, 32'h0);
        cyc(1, GLB, 1); cyc(0, GLB, 0);
        chk("R10 both on", {30'd0, host_fast_o, host_norm_o}, 32'h3);
        cyc(1, HICLR, 0); cyc(0, GLB, 0);
        chk("R10 fast host disabled", {30'd0, host_fast_o, host_norm_o}, 32'h1);
        cyc(1, HISET, 0);
        chk_all("R7 directed");

        // random phase
        for (int n = 0; n < 600; n++) begin
            int op = $urandom_range(15, 0);
            logic [31:0] rv = $urandom;
            cur_in = cur_in ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
            case (op)
                0: cyc(1, SICLR, 32'($urandom_range(70, 0)));
                1: cyc(1, STAT + 7'($urandom_range(1, 0)), rv);
                2: cyc(1, EISET, 32'($urandom_range(70, 0)));
                3: cyc(1, EICLR, 32'($urandom_range(70, 0)));
                4: cyc(1, MAP + 7'($urandom_range(15, 0)), rv);
                5: cyc(1, TYP + 7'($urandom_range(1, 0)), rv);
                6: cyc(1, POL + 7'($urandom_range(1, 0)), rv | $urandom);
                7: cyc(1, HEN, 32'($urandom_range(3, 0)));
                8: cyc(1, GLB, 32'($urandom_range(1, 0) | $urandom_range(1, 0)));
                9: cyc(1, ESET + 7'($urandom_range(1, 0)), rv);
                default: cyc(0, GLB, 0);
            endcase
            chk_all("R2 R3 R4 R5 random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule